// File: doc/BRIEF.md
# Monochrome Blit Raster-Op Datapath

This block is the word path of a one-bit-per-pixel frame buffer. Each source word that the host pushes in is first aligned. In block-transfer mode it is joined with the word pushed before it and shifted right, so that pixels cross word boundaries. It is then passed through a source selector and combined with the destination word by a 4-bit raster operation. Finally it is merged lane by lane under a write-enable mask. One cycle after each source strobe, the block presents the merged word for writing back to memory.

A small bank of control registers sets the mode, the shift amount, the source selection, the raster operation and the lane mask. A command register restores the defaults or blanks the display. Copy software sets the shift to (destination x − source x) mod 16. When alignment needs pixels from a word before the first word written, software issues one priming strobe first. It uses narrowed masks on the first and last word of each row.

Top module: `mono_blit_rop`

## Requirements
- R1: After reset the registers read mode=0x00E0, config=0x008B, source-select=0x00C0, raster-op=0x0300, lane mask=0xFFFF; `disp_en` is 1 and `wr_valid` is 0.
- R2: Register addresses are 0 mode, 1 config, 2 source-select, 3 command, 4 raster-op, 5 lane mask. The 8-bit registers take `reg_wdata[7:0]` and read back zero-extended. The active raster-op code is raster-op register bits [11:8].
- R3: In block-transfer mode (mode bits [7:5]=100), the aligned source is the low 16 bits of {previous word, current word} shifted right by mode bits [3:0]. Bit 4 of the shift field has no effect.
- R4: The previous-word register takes `src_word` on every strobe in every mode, so a priming strobe supplies the left-hand bits of the next aligned word.
- R5: In normal (111) and vector (010) modes the source word passes unshifted, whatever the shift field holds.
- R6: Source-select bits [7:6]: 00 gives all ones, 01 copies bit 0 of the aligned word to all 16 bits, 10 and 11 pass the aligned word.
- R7: With config bit 4 set, the result for code 0..F is 0, S&D, S&~D, S, ~S&D, D, S^D, S|D, ~(S|D), ~(S^D), ~D, S|~D, ~S, ~S|D, ~(S&D), all ones.
- R8: With config bit 4 clear, the result is the selected source whatever the code.
- R9: Lane mask bit i = 1 writes result bit i; bit i = 0 keeps destination bit i (MSB is the leftmost pixel).
- R10: `wr_valid` is high exactly in the cycle after a cycle with `src_valid` high, and `wr_data` then reflects the inputs and registers of that strobe cycle.
- R11: Command writes: 0x80 restores every register to its reset value and unblanks; 0x00 blanks; 0x01 unblanks; other values change nothing. `disp_en` = config bit 0 AND not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| src_valid | input | 1 | Source word strobe |
| src_word | input | 16 | Source word from memory |
| dst_word | input | 16 | Destination word read, same cycle as strobe |
| wr_valid | output | 1 | Merged write word valid |
| wr_data | output | 16 | Merged word to write back |
| disp_en | output | 1 | Display enable |

## Verification
Cycle-level checks cover the following: the write strobe follows each source strobe by exactly one cycle and appears at no other time. Masked-off lanes always carry the destination bits. The all-ones code with a full mask and the operation enabled yields all ones. A reset command restores the mode register. The truth of the full operation table, the shift across the previous word, the priming behaviour, the bypass in non-blit modes and the source selections depend on data patterns. Only the bench's scenarios can show these, comparing against expected words worked out by hand.

// File: rtl/mono_blit_rop.sv
module mono_blit_rop #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         src_valid,
  input  logic [W-1:0] src_word,
  input  logic [W-1:0] dst_word,
  output logic         wr_valid,
  output logic [W-1:0] wr_data,
  output logic         disp_en
);
  localparam int SW = $clog2(W);
  localparam logic [7:0]   MODE_RST = 8'hE0;
  localparam logic [7:0]   CFG_RST  = 8'h8B;
  localparam logic [7:0]   SEL_RST  = 8'hC0;
  localparam logic [W-1:0] ROP_RST  = W'(16'h0300);

  logic [7:0]   mode_q, cfg_q, sel_q;
  logic [W-1:0] rop_q, mask_q, prev_q;
  logic         blank_q;

  logic cmd_wr;
  assign cmd_wr = reg_we && reg_addr == 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST; cfg_q <= CFG_RST; sel_q <= SEL_RST;
      rop_q <= ROP_RST; mask_q <= '1; blank_q <= 1'b0;
    end else if (cmd_wr && reg_wdata[7:0] == 8'h80) begin
      mode_q <= MODE_RST; cfg_q <= CFG_RST; sel_q <= SEL_RST;
      rop_q <= ROP_RST; mask_q <= '1; blank_q <= 1'b0;
    end else if (cmd_wr && reg_wdata[7:1] == 7'd0) begin
      blank_q <= ~reg_wdata[0];
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: mode_q <= reg_wdata[7:0];
        3'd1: cfg_q  <= reg_wdata[7:0];
        3'd2: sel_q  <= reg_wdata[7:0];
        3'd4: rop_q  <= reg_wdata;
        3'd5: mask_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = W'(mode_q);
      3'd1: reg_rdata = W'(cfg_q);
      3'd2: reg_rdata = W'(sel_q);
      3'd3: reg_rdata = W'(~blank_q);
      3'd4: reg_rdata = rop_q;
      3'd5: reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign disp_en = cfg_q[0] & ~blank_q;

  logic           blit;
  logic [SW-1:0]  sh;
  logic [2*W-1:0] joined;
  logic [W-1:0]   aligned, s, d, res;
  logic [3:0]     code;

  assign blit    = mode_q[7:5] == 3'b100;
  assign sh      = blit ? mode_q[SW-1:0] : '0;
  assign joined  = {prev_q, src_word} >> sh;
  assign aligned = joined[W-1:0];
  assign d       = dst_word;
  assign code    = rop_q[11:8];

  always_comb begin
    case (sel_q[7:6])
      2'b00:   s = '1;
      2'b01:   s = {W{aligned[0]}};
      default: s = aligned;
    endcase
  end

  always_comb begin
    case (code)
      4'h0: res = '0;
      4'h1: res = s & d;
      4'h2: res = s & ~d;
      4'h3: res = s;
      4'h4: res = ~s & d;
      4'h5: res = d;
      4'h6: res = s ^ d;
      4'h7: res = s | d;
      4'h8: res = ~(s | d);
      4'h9: res = ~(s ^ d);
      4'hA: res = ~d;
      4'hB: res = s | ~d;
      4'hC: res = ~s;
      4'hD: res = ~s | d;
      4'hE: res = ~(s & d);
      default: res = '1;
    endcase
    if (!cfg_q[4]) res = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0; wr_valid <= 1'b0; wr_data <= '0;
    end else begin
      wr_valid <= src_valid;
      if (src_valid) begin
        prev_q  <= src_word;
        wr_data <= (res & mask_q) | (d & ~mask_q);
      end
    end
  end
endmodule

module mono_blit_rop_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         src_valid,
  input logic [W-1:0] dst_word,
  input logic         wr_valid,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] rop_q,
  input logic [7:0]   cfg_q,
  input logic [7:0]   mode_q
);
  AST_WR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> wr_valid); // R10
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> !wr_valid); // R10
  AST_MASKED_LANES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> (((wr_data ^ $past(dst_word)) & ~$past(mask_q)) == '0)); // R9
  AST_ROP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && rop_q[11:8] == 4'hF && cfg_q[4] && mask_q == '1) |=> wr_data == '1); // R7
  AST_CMD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && reg_wdata[7:0] == 8'h80) |=> mode_q == 8'hE0); // R11
endmodule

bind mono_blit_rop mono_blit_rop_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .src_valid(src_valid), .dst_word(dst_word),
  .wr_valid(wr_valid), .wr_data(wr_data), .mask_q(mask_q), .rop_q(rop_q),
  .cfg_q(cfg_q), .mode_q(mode_q)
);

// File: tb/sim_mono_blit_rop.sv
`timescale 1ns/1ps
module sim_mono_blit_rop;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        src_valid = 0;
  logic [15:0] src_word = 0, dst_word = 0, wr_data;
  logic        wr_valid, disp_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mono_blit_rop u0 (.*);

  localparam logic [19:0] ROP_VEC [16] = '{
    {4'h0,16'h0000},{4'h1,16'h0305},{4'h2,16'h3050},{4'h3,16'h3355},
    {4'h4,16'h0C0A},{4'h5,16'h0F0F},{4'h6,16'h3C5A},{4'h7,16'h3F5F},
    {4'h8,16'hC0A0},{4'h9,16'hC3A5},{4'hA,16'hF0F0},{4'hB,16'hF3F5},
    {4'hC,16'hCCAA},{4'hD,16'hCFAF},{4'hE,16'hFCFA},{4'hF,16'hFFFF}};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic strobe(logic [15:0] s, logic [15:0] d, output logic [15:0] r);
    @(negedge clk); src_valid = 1; src_word = s; dst_word = d;
    @(negedge clk); src_valid = 0;
    check("R10 valid", {15'd0, wr_valid}, 16'd1);
    r = wr_data;
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); check("R1 mode", v, 16'h00E0);
    rd(1, v); check("R1 config", v, 16'h008B);
    rd(2, v); check("R1 srcsel", v, 16'h00C0);
    rd(4, v); check("R1 rop", v, 16'h0300);
    rd(5, v); check("R1 mask", v, 16'hFFFF);
    check("R1 disp_en", {15'd0, disp_en}, 16'd1);
    check("R1 wr_valid", {15'd0, wr_valid}, 16'd0);

    // R2 readback, 8-bit truncation
    wr(2, 16'hAB40); rd(2, v); check("R2 srcsel 8-bit", v, 16'h0040);
    wr(2, 16'h00C0);

    // R7 table walk with the operation enabled
    wr(1, 16'h009B);
    foreach (ROP_VEC[i]) begin
      wr(4, {4'h0, ROP_VEC[i][19:16], 8'h00});
      strobe(16'h3355, 16'h0F0F, v);
      check($sformatf("R7 code %h", ROP_VEC[i][19:16]), v, ROP_VEC[i][15:0]);
    end
    // R2 code taken from bits [11:8] only
    wr(4, 16'h6F06);
    strobe(16'h3355, 16'h0F0F, v); check("R2 rop field", v, 16'hFFFF);

    // R8 operation disabled passes source
    wr(4, 16'h0000); wr(1, 16'h008B);
    strobe(16'h3355, 16'h0F0F, v); check("R8 disabled", v, 16'h3355);

    // R5 bypass in normal and vector modes
    wr(0, 16'h00E5); strobe(16'h1234, 16'h0, v); check("R5 normal", v, 16'h1234);
    wr(0, 16'h0045); strobe(16'h1234, 16'h0, v); check("R5 vector", v, 16'h1234);

    // R3/R4 blit shift with priming strobe
    wr(0, 16'h0085);
    strobe(16'hABCD, 16'h0, v);
    strobe(16'h1234, 16'h0, v); check("R3 R4 shift5", v, 16'h6891);
    wr(0, 16'h0092);
    strobe(16'h8001, 16'h0, v);
    strobe(16'h0000, 16'h0, v); check("R3 shift bit4 ignored", v, 16'h4000);
    // R4 previous word loaded in normal mode feeds blit
    wr(0, 16'h00E0); strobe(16'hFFFF, 16'h0, v);
    wr(0, 16'h0084); strobe(16'h0000, 16'h0, v); check("R4 prev from normal", v, 16'hF000);
    wr(0, 16'h00E0);

    // R6 source select
    wr(2, 16'h0000); strobe(16'h1234, 16'h0, v); check("R6 ones", v, 16'hFFFF);
    wr(2, 16'h0040); strobe(16'h0001, 16'h0, v); check("R6 rep 1", v, 16'hFFFF);
    strobe(16'hFFFE, 16'hFFFF, v); check("R6 rep 0", v, 16'h0000);
    wr(2, 16'h0080); strobe(16'h5A5A, 16'h0, v); check("R6 sel 10", v, 16'h5A5A);
    wr(2, 16'h00C0);

    // R9 lane mask
    wr(5, 16'hF000); strobe(16'h0000, 16'hFFFF, v); check("R9 mask F000", v, 16'h0FFF);
    wr(5, 16'h1FFF); strobe(16'h0000, 16'hFFFF, v); check("R9 start edge", v, 16'hE000);
    wr(5, 16'hFFFF);

    // R10 no strobe, no write
    @(negedge clk); @(negedge clk);
    check("R10 idle", {15'd0, wr_valid}, 16'd0);

    // R11 commands and display enable
    wr(3, 16'h0000); check("R11 blank", {15'd0, disp_en}, 16'd0);
    wr(3, 16'h0001); check("R11 unblank", {15'd0, disp_en}, 16'd1);
    wr(1, 16'h008A); check("R11 cfg bit0", {15'd0, disp_en}, 16'd0);
    wr(0, 16'h0047); wr(3, 16'h0055);
    rd(0, v); check("R11 other cmd ignored", v, 16'h0047);
    wr(3, 16'h0000); wr(3, 16'h0080);
    rd(0, v); check("R11 reset mode", v, 16'h00E0);
    rd(1, v); check("R11 reset config", v, 16'h008B);
    rd(5, v); check("R11 reset mask", v, 16'hFFFF);
    check("R11 reset unblank", {15'd0, disp_en}, 16'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule